// File: doc/BRIEF.md
# Iterative Fibonacci Sequence Engine

This block returns the Fibonacci number at a requested index. The sequence starts at index one, with the first two terms both equal to 1, and index zero gives 0. A caller puts the index on `idx` and raises `go` for one clock. The engine captures the index, adds once per clock, and then raises `done` with the value on `result`. The value and the flag stay as they are until the caller starts the next request.

The control and the datapath are two separate modules. A four-state controller (idle, init, loop, finished) drives the datapath through a small bundle of strobes. The datapath keeps the two most recent terms, an iteration counter, the captured index and the result register. Indices 1 and 2 skip the loop entirely. Every larger index costs one clock per addition. The result is kept modulo 2^`RES_W`.

Top module: `fib_core`

## Requirements
- R1: A synchronous active-high `rst` sets `done` to 0 and `result` to 0 on the next clock edge and abandons any computation in progress. After reset the engine accepts a new request.
- R2: A request with index 0 finishes with `result` equal to 0.
- R3: A request with index 1 or 2 finishes with `result` equal to 1, without running the addition loop.
- R4: For index k of 3 or more, `result` equals Fib(k) with Fib(1)=Fib(2)=1, taken modulo 2^`RES_W`. This gives Fib(3)=2, Fib(10)=55, Fib(20)=6765 and Fib(30)=832040.
- R5: When `go` is sampled high while the engine is idle or finished, the engine accepts the request and `done` is 0 in the following cycle.
- R6: Once `done` rises it stays at 1, and `result` does not change, until the next accepted `go`.
- R7: A `go` pulse that arrives while a computation is running is ignored. The running request's result is unchanged and no extra completion is produced.
- R8: If `go` is accepted in cycle c, `done` first reads 1 in cycle c+2 for index 0, 1 or 2, and in cycle c+k for index k of 3 or more.
- R9: The index is captured in the cycle `go` is accepted. Later changes on `idx` do not affect the running request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, sampled only when not busy |
| idx | input | IDX_W | Requested sequence index |
| result | output | RES_W | Fibonacci value of the last finished request |
| done | output | 1 | High while the result is valid |

## Verification
The bench builds the engine with its defaults: `RES_W`=32 and `IDX_W`=6. This lets it reach every index up to 63. Index 47 is the largest term that still fits in 32 bits. Indices 48 and 63 exercise the modulo wrap. Index 30 is the largest value named in the requirements. The 6-bit index also keeps the longest request at 63 cycles, so the bench can run all the latency checks.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_LOOP = 2'd2,
    ST_DONE = 2'd3
  } fibState_t;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_SUM  = 1'b1
  } resSel_t;

  typedef struct packed {
    logic    latchIdx;
    logic    initLoad;
    logic    step;
    logic    capture;
    resSel_t resSel;
  } fibCtrl_t;

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  logic     idxSmall,
  input  logic     lastStep,
  output fibCtrl_t strb,
  output logic     done
);

  fibState_t st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt = st;
    strb = '0;
    strb.resSel = SEL_BASE;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (go) begin
          strb.latchIdx = 1'b1;
          nxt = ST_INIT;
        end
      end
      ST_INIT: begin
        strb.initLoad = 1'b1;
        if (idxSmall) begin
          strb.capture = 1'b1;
          nxt = ST_DONE;
        end else begin
          nxt = ST_LOOP;
        end
      end
      ST_LOOP: begin
        strb.step = 1'b1;
        if (lastStep) begin
          strb.capture = 1'b1;
          strb.resSel = SEL_SUM;
          nxt = ST_DONE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign done = (st == ST_DONE);

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath
  import fib_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  fibCtrl_t         strb,
  input  logic [IDX_W-1:0] idx,
  output logic             idxSmall,
  output logic             lastStep,
  output logic [RES_W-1:0] result
);

  localparam logic [IDX_W-1:0] TWO = IDX_W'(2);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] cntReg;
  logic [RES_W-1:0] prevReg;
  logic [RES_W-1:0] curReg;
  logic [RES_W-1:0] resReg;
  logic [RES_W-1:0] sumVal;
  logic [RES_W-1:0] baseVal;

  assign sumVal   = prevReg + curReg;
  assign baseVal  = (idxReg == '0) ? '0 : RES_W'(1);
  assign idxSmall = (idxReg <= TWO);
  assign lastStep = (cntReg == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idxReg <= '0;
    end else if (strb.latchIdx) begin
      idxReg <= idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevReg <= '0;
      curReg  <= '0;
      cntReg  <= '0;
    end else if (strb.initLoad) begin
      prevReg <= RES_W'(1);
      curReg  <= RES_W'(1);
      cntReg  <= idxReg - TWO;
    end else if (strb.step) begin
      prevReg <= curReg;
      curReg  <= sumVal;
      cntReg  <= cntReg - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resReg <= '0;
    end else if (strb.capture) begin
      resReg <= (strb.resSel == SEL_SUM) ? sumVal : baseVal;
    end
  end

  assign result = resReg;

endmodule

// File: rtl/fib_core.sv
module fib_core
  import fib_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [IDX_W-1:0] idx,
  output logic [RES_W-1:0] result,
  output logic             done
);

  fibCtrl_t ctrlStrb;
  logic     idxSmall;
  logic     lastStep;

  fib_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .idxSmall (idxSmall),
    .lastStep (lastStep),
    .strb     (ctrlStrb),
    .done     (done)
  );

  fib_datapath #(.RES_W(RES_W), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (ctrlStrb),
    .idx      (idx),
    .idxSmall (idxSmall),
    .lastStep (lastStep),
    .result   (result)
  );

endmodule

// File: rtl/fib_core_chk.sv
module fib_core_chk #(
  parameter int RES_W = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             go,
  input logic [IDX_W-1:0] idx,
  input logic [RES_W-1:0] result,
  input logic             done
);

  logic             busyM;
  logic [IDX_W-1:0] idxM;
  logic [IDX_W:0]   cntM;
  logic [IDX_W:0]   expLat;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyM <= 1'b0;
      idxM  <= '0;
      cntM  <= '0;
    end else if (!busyM && go) begin
      busyM <= 1'b1;
      idxM  <= idx;
      cntM  <= (IDX_W+1)'(1);
    end else if (busyM && !done) begin
      cntM  <= cntM + (IDX_W+1)'(1);
    end else if (busyM && done) begin
      busyM <= go;
      if (go) begin
        idxM <= idx;
        cntM <= (IDX_W+1)'(1);
      end
    end
  end

  always_comb begin
    if (idxM <= IDX_W'(2)) expLat = (IDX_W+1)'(2);
    else                   expLat = {1'b0, idxM};
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !done);

  // R2
  p_zero_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (busyM && done && idxM == '0) |-> (result == '0));

  // R3
  p_small_idx_r3: assert property (@(posedge clk) disable iff (rst)
    (busyM && done && (idxM == IDX_W'(1) || idxM == IDX_W'(2))) |-> (result == RES_W'(1)));

  // R5
  p_done_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (done && go) |=> !done);

  // R6
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> (done && $stable(result)));

  // R8
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (busyM && done) |-> (cntM == expLat));

endmodule

bind fib_core fib_core_chk #(.RES_W(RES_W), .IDX_W(IDX_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .go     (go),
  .idx    (idx),
  .result (result),
  .done   (done)
);

// File: tb/fib_core_tb_top.sv
module fib_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 32;
  localparam int IDX_W = 6;
  localparam int WATCHDOG = 20000;

  typedef struct {
    int          idxVal;
    logic [31:0] expVal;
    int          issueCyc;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             go = 1'b0;
  logic [IDX_W-1:0] idx = '0;
  logic [RES_W-1:0] result;
  logic             done;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic prevDone = 1'b0;
  expItem_t expQ[$];

  fib_core #(.RES_W(RES_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .go(go), .idx(idx), .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] fibRef(int k);
    logic [31:0] a = 32'd0;
    logic [31:0] b = 32'd1;
    logic [31:0] t;
    if (k == 0) return 32'd0;
    for (int i = 1; i < k; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return b;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string reqFor(int k);
    if (k == 0) return "R2";
    if (k <= 2) return "R3";
    return "R4";
  endfunction

  // monitor: pops expectations when done rises
  always @(negedge clk) begin
    if (rst) begin
      prevDone <= 1'b0;
    end else begin
      if (done && !prevDone) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected completion", 1, 0);
        end else begin
          expItem_t it;
          int lat;
          it = expQ.pop_front();
          lat = (it.idxVal <= 2) ? 2 : it.idxVal;
          check(result == it.expVal, reqFor(it.idxVal), result, it.expVal);
          check(cyc == it.issueCyc + lat, "R8 latency", cyc - it.issueCyc, lat);
        end
      end
      prevDone <= done;
    end
  end

  task automatic runReq(int k, bit pokeMid, bit changeIdx);
    expItem_t it;
    logic [31:0] ev;
    @(negedge clk);
    go = 1'b1;
    idx = IDX_W'(k);
    ev = fibRef(k);
    it.idxVal = k;
    it.expVal = ev;
    it.issueCyc = cyc;
    expQ.push_back(it);
    @(negedge clk);
    go = 1'b0;
    check(done == 1'b0, "R5 done low after accept", done, 0);
    if (changeIdx) idx = IDX_W'((k + 11) % 64);   // R9
    if (pokeMid && k >= 5) begin
      @(negedge clk);
      go = 1'b1;                                   // R7
      idx = IDX_W'(7);
      @(negedge clk);
      go = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R6 done held", done, 1);
    check(result == ev, "R6 result held", result, ev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(result == '0, "R1 result after reset", result, 0);
    rst = 1'b0;

    runReq(1, 0, 0);
    runReq(2, 0, 0);
    runReq(0, 0, 0);
    runReq(3, 0, 0);
    runReq(10, 0, 0);
    runReq(20, 1, 0);
    runReq(30, 0, 1);
    runReq(12, 1, 1);
    runReq(47, 0, 0);
    runReq(48, 0, 0);
    runReq(63, 0, 0);

    // R1: reset in the middle of a computation
    @(negedge clk);
    go = 1'b1;
    idx = IDX_W'(30);
    @(negedge clk);
    go = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expQ.delete();
    check(done == 1'b0, "R1 done after mid-run reset", done, 0);
    check(result == '0, "R1 result after mid-run reset", result, 0);
    repeat (40) @(negedge clk);
    check(done == 1'b0, "R1 abandoned run stays idle", done, 0);
    runReq(5, 0, 0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R7 all expectations consumed", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule